// File: doc/BRIEF.md
# Debug Request/Acknowledge Mailbox

This block is the status and buffer part of a debug memory. It sits between a debug module and a CPU core that is parked in debug mode. The CPU reaches the block over a simple memory-mapped bus. That bus has an address, a write strobe with per-byte enables, write data, a read strobe and registered read data. The debug module side has two request pulse inputs, one to resume and one to execute the program buffer. It also has four status outputs and direct word ports into the two buffers.

The block decodes a 256-byte window made of four 64-byte regions, in this order:

| Offset in window | Region |
|---|---|
| +0x00 | code area |
| +0x40 | program buffer |
| +0x80 | data buffer |
| +0xC0 | status word |

The code area is served elsewhere, so reads of it here return zero. In the status word each byte lane has a split meaning. A CPU read returns a pending request from the debug module. A CPU write of any value is an acknowledge event from the CPU.

The parked CPU polls the execute request before the resume request, so execute wins when both are pending. The block only has to hold both requests independently. The exception entry sits at code base +0 and the normal entry at code base +8. Both offsets are exported as package constants.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset `dmHalted`, `dmResuming`, `dmExecuting`, `dmException` and `cpuRdata` are all zero, and a read of the status word returns 0.
- R2: A one-cycle `dmResumeReq` pulse sets a sticky resume flag. While the flag is set, a status read returns 0x01 in bits 15:8. A CPU write with `cpuBe[1]` set (lane 1) clears the flag.
- R3: A one-cycle `dmExecReq` pulse sets a sticky execute flag. While the flag is set, a status read returns 0x01 in bits 23:16. A CPU write with `cpuBe[2]` set (lane 2) clears the flag.
- R4: The two flags are held independently, so both can be pending at once. A request pulse that arrives in the same cycle as its own acknowledge write leaves the flag set.
- R5: A write of any value to lane 0 of the status word sets `dmHalted` from the next cycle. A lane-1 write clears it, and the clear wins when both lanes are written together.
- R6: Writes to lanes 1, 2 and 3 of the status word each give a one-cycle pulse on `dmResuming`, `dmExecuting` and `dmException` respectively. The pulse appears in the cycle after the write, and several lanes may be written in one access.
- R7: Lanes 0 and 3 of the status word always read as zero.
- R8: The debug module writes program buffer word i through `dmPbufWe`/`dmPbufIdx`, and the CPU reads it at window +0x40+4*i. CPU writes to the program buffer have no effect.
- R9: The CPU writes data buffer word i at window +0x80+4*i under byte enables. The debug module writes whole words and reads `dmDbufRdata` combinationally. When both sides write the same word in one cycle, the debug module's value is stored.
- R10: Accesses outside the window return zero and change nothing. Reads of the code area return zero.
- R11: `cpuRdata` is loaded at the clock edge where `cpuRe` is high, and it holds its value while `cpuRe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | ADDR_W | CPU byte address |
| cpuWe | input | 1 | CPU write strobe |
| cpuBe | input | 4 | CPU byte enables |
| cpuWdata | input | 32 | CPU write data |
| cpuRe | input | 1 | CPU read strobe |
| cpuRdata | output | 32 | Registered CPU read data |
| dmResumeReq | input | 1 | Resume request pulse |
| dmExecReq | input | 1 | Execute request pulse |
| dmHalted | output | 1 | CPU parked in debug mode |
| dmResuming | output | 1 | Resume acknowledge pulse |
| dmExecuting | output | 1 | Execute acknowledge pulse |
| dmException | output | 1 | Debug-mode exception pulse |
| dmPbufWe | input | 1 | Program buffer write strobe |
| dmPbufIdx | input | IDX_W | Program buffer word index |
| dmPbufWdata | input | 32 | Program buffer write data |
| dmDbufWe | input | 1 | Data buffer write strobe |
| dmDbufIdx | input | IDX_W | Data buffer word index |
| dmDbufWdata | input | 32 | Data buffer write data |
| dmDbufRdata | output | 32 | Data buffer read data at `dmDbufIdx` |

## Verification
The bench builds the block with its default parameters: window base 0xFFFFF800 and 64-byte regions, which gives 16 words per buffer. With these values the first and last buffer words (index 0 and 15) can be reached. An address that matches the status offset in its low bits but lies outside the window can also be produced, which exercises the window compare separately from the region decode. Same-cycle cases come within reach as well: a request arriving with its own acknowledge, and both sides writing one data word together.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

  typedef enum logic [1:0] {
    RGN_CODE = 2'd0,
    RGN_PBUF = 2'd1,
    RGN_DBUF = 2'd2,
    RGN_SREG = 2'd3
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    rdEn;
    region_e rdRgn;
    logic    dbufWr;
  } dpStrobe_t;

  localparam int LANE_HALT   = 0;
  localparam int LANE_RESUME = 1;
  localparam int LANE_EXEC   = 2;
  localparam int LANE_EXC    = 3;

  localparam logic [7:0] FLAG_ON = 8'h01;

  // entry offsets inside the code area
  localparam int EXC_ENTRY_OFS    = 0;
  localparam int NORMAL_ENTRY_OFS = 8;

endpackage

// File: rtl/dbgmb_ctrl.sv
module dbgmb_ctrl
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFFF800,
  parameter int REGION_BYTES = 64,
  localparam int REG_LSB = $clog2(REGION_BYTES),
  localparam int WIN_LSB = REG_LSB + 2,
  localparam int IDX_W = REG_LSB - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [3:0]        cpuBe,
  input  logic              cpuRe,
  input  logic              dmResumeReq,
  input  logic              dmExecReq,
  output logic              dmHalted,
  output logic              dmResuming,
  output logic              dmExecuting,
  output logic              dmException,
  output dpStrobe_t         strb,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              resumePend,
  output logic              execPend
);

  logic    inWin;
  region_e rgn;
  logic    sregWr;
  logic [3:0] ackLane;

  always_comb begin
    inWin   = (cpuAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
    rgn     = region_e'(cpuAddr[WIN_LSB-1:REG_LSB]);
    wordIdx = cpuAddr[REG_LSB-1:2];
    sregWr  = cpuWe && inWin && (rgn == RGN_SREG);
    ackLane = {4{sregWr}} & cpuBe;
  end

  always_comb begin
    strb.rdEn   = cpuRe;
    strb.rdRgn  = inWin ? rgn : RGN_CODE;
    strb.dbufWr = cpuWe && inWin && (rgn == RGN_DBUF);
  end

  // sticky request flags: a new request beats a same-cycle acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumePend <= 1'b0;
      execPend   <= 1'b0;
    end else begin
      resumePend <= dmResumeReq | (resumePend & ~ackLane[LANE_RESUME]);
      execPend   <= dmExecReq   | (execPend   & ~ackLane[LANE_EXEC]);
    end
  end

  // halted state: resume acknowledge has precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmHalted <= 1'b0;
    end else if (ackLane[LANE_RESUME]) begin
      dmHalted <= 1'b0;
    end else if (ackLane[LANE_HALT]) begin
      dmHalted <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmResuming  <= 1'b0;
      dmExecuting <= 1'b0;
      dmException <= 1'b0;
    end else begin
      dmResuming  <= ackLane[LANE_RESUME];
      dmExecuting <= ackLane[LANE_EXEC];
      dmException <= ackLane[LANE_EXC];
    end
  end

endmodule

// File: rtl/dbgmb_data.sv
module dbgmb_data
  import dbgmb_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [3:0]       cpuBe,
  input  logic [31:0]      cpuWdata,
  input  logic             resumePend,
  input  logic             execPend,
  input  logic             dmPbufWe,
  input  logic [IDX_W-1:0] dmPbufIdx,
  input  logic [31:0]      dmPbufWdata,
  input  logic             dmDbufWe,
  input  logic [IDX_W-1:0] dmDbufIdx,
  input  logic [31:0]      dmDbufWdata,
  output logic [31:0]      dmDbufRdata,
  output logic [31:0]      cpuRdata
);

  logic [31:0]      pbuf [WORDS];
  logic [3:0][7:0]  dbuf [WORDS];
  logic [31:0]      statusWord;
  logic [31:0]      rdMux;

  // program buffer: written only from the debug module side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) pbuf[w] <= '0;
    end else if (dmPbufWe) begin
      pbuf[dmPbufIdx] <= dmPbufWdata;
    end
  end

  // data buffer: one register per byte, debug module wins a conflict
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dbuf[w][b] <= '0;
        end else if (dmDbufWe && (dmDbufIdx == IDX_W'(w))) begin
          dbuf[w][b] <= dmDbufWdata[8*b +: 8];
        end else if (strb.dbufWr && cpuBe[b] && (wordIdx == IDX_W'(w))) begin
          dbuf[w][b] <= cpuWdata[8*b +: 8];
        end
      end
    end
  end

  assign dmDbufRdata = dbuf[dmDbufIdx];

  always_comb begin
    statusWord = '0;
    statusWord[8*LANE_RESUME +: 8] = resumePend ? FLAG_ON : 8'h00;
    statusWord[8*LANE_EXEC +: 8]   = execPend   ? FLAG_ON : 8'h00;
    case (strb.rdRgn)
      RGN_PBUF: rdMux = pbuf[wordIdx];
      RGN_DBUF: rdMux = dbuf[wordIdx];
      RGN_SREG: rdMux = statusWord;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdata <= '0;
    end else if (strb.rdEn) begin
      cpuRdata <= rdMux;
    end
  end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFFF800,
  parameter int REGION_BYTES = 64,
  localparam int IDX_W = $clog2(REGION_BYTES) - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [3:0]        cpuBe,
  input  logic [31:0]       cpuWdata,
  input  logic              cpuRe,
  output logic [31:0]       cpuRdata,
  input  logic              dmResumeReq,
  input  logic              dmExecReq,
  output logic              dmHalted,
  output logic              dmResuming,
  output logic              dmExecuting,
  output logic              dmException,
  input  logic              dmPbufWe,
  input  logic [IDX_W-1:0]  dmPbufIdx,
  input  logic [31:0]       dmPbufWdata,
  input  logic              dmDbufWe,
  input  logic [IDX_W-1:0]  dmDbufIdx,
  input  logic [31:0]       dmDbufWdata,
  output logic [31:0]       dmDbufRdata
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] wordIdx;
  logic             resumePend;
  logic             execPend;

  dbgmb_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .REGION_BYTES(REGION_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuBe(cpuBe), .cpuRe(cpuRe),
    .dmResumeReq(dmResumeReq), .dmExecReq(dmExecReq),
    .dmHalted(dmHalted), .dmResuming(dmResuming),
    .dmExecuting(dmExecuting), .dmException(dmException),
    .strb(strb), .wordIdx(wordIdx),
    .resumePend(resumePend), .execPend(execPend)
  );

  dbgmb_data #(.IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN),
    .strb(strb), .wordIdx(wordIdx),
    .cpuBe(cpuBe), .cpuWdata(cpuWdata),
    .resumePend(resumePend), .execPend(execPend),
    .dmPbufWe(dmPbufWe), .dmPbufIdx(dmPbufIdx), .dmPbufWdata(dmPbufWdata),
    .dmDbufWe(dmDbufWe), .dmDbufIdx(dmDbufIdx), .dmDbufWdata(dmDbufWdata),
    .dmDbufRdata(dmDbufRdata),
    .cpuRdata(cpuRdata)
  );

endmodule

// File: rtl/dbgmb_chk.sv
module dbgmb_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFFF800,
  parameter int REGION_BYTES = 64,
  localparam int REG_LSB = $clog2(REGION_BYTES),
  localparam int WIN_LSB = REG_LSB + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuWe,
  input logic [3:0]        cpuBe,
  input logic              cpuRe,
  input logic [31:0]       cpuRdata,
  input logic              dmHalted,
  input logic              dmResuming,
  input logic              dmExecuting,
  input logic              dmException
);

  logic [3:0] laneWr;
  assign laneWr = {4{cpuWe && (cpuAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB])
                   && (cpuAddr[WIN_LSB-1:REG_LSB] == 2'd3)}} & cpuBe;

  // R5
  halt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmHalted) |-> $past(laneWr[0]));

  // R5
  halt_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(laneWr[1]) |-> !dmHalted);

  // R6
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmResuming |-> $past(laneWr[1]));

  // R6
  exec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(laneWr[2]) |-> dmExecuting);

  // R6
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmException |-> $past(laneWr[3]));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cpuRe) |-> $stable(cpuRdata));

endmodule

bind dbg_mailbox dbgmb_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .REGION_BYTES(REGION_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuBe(cpuBe),
  .cpuRe(cpuRe), .cpuRdata(cpuRdata), .dmHalted(dmHalted),
  .dmResuming(dmResuming), .dmExecuting(dmExecuting), .dmException(dmException)
);

// File: tb/dbg_mailbox_test.sv
`timescale 1ns/1ps
module dbg_mailbox_test;

  localparam logic [31:0] CODE = 32'hFFFFF800;
  localparam logic [31:0] PBUF = 32'hFFFFF840;
  localparam logic [31:0] DBUF = 32'hFFFFF880;
  localparam logic [31:0] SREG = 32'hFFFFF8C0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic cpuWe = 1'b0;
  logic [3:0] cpuBe = '0;
  logic [31:0] cpuWdata = '0;
  logic cpuRe = 1'b0;
  logic [31:0] cpuRdata;
  logic dmResumeReq = 1'b0;
  logic dmExecReq = 1'b0;
  logic dmHalted, dmResuming, dmExecuting, dmException;
  logic dmPbufWe = 1'b0;
  logic [3:0] dmPbufIdx = '0;
  logic [31:0] dmPbufWdata = '0;
  logic dmDbufWe = 1'b0;
  logic [3:0] dmDbufIdx = '0;
  logic [31:0] dmDbufWdata = '0;
  logic [31:0] dmDbufRdata;

  int nChk = 0;
  int nBad = 0;
  logic obsRes, obsExe, obsExc, obsHalt;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  dbg_mailbox uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuWr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuBe = be; cpuWdata = d; cpuWe = 1'b1;
    @(posedge clk); #1;
    obsRes = dmResuming; obsExe = dmExecuting; obsExc = dmException; obsHalt = dmHalted;
    cpuWe = 1'b0; cpuBe = '0;
  endtask

  task automatic cpuRd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRe = 1'b1;
    @(posedge clk); #1;
    d = cpuRdata; cpuRe = 1'b0;
  endtask

  task automatic dmReq(input logic res, input logic exe);
    @(negedge clk);
    dmResumeReq = res; dmExecReq = exe;
    @(posedge clk); #1;
    dmResumeReq = 1'b0; dmExecReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 halted", 32'(dmHalted), 0);
    chk("R1 pulses", {29'd0, dmResuming, dmExecuting, dmException}, 0);
    chk("R1 rdata", cpuRdata, 0);
    cpuRd(SREG, rd);
    chk("R1 status", rd, 0);
  endtask

  task automatic testHalt();
    cpuWr(SREG, 4'b0001, 32'h000000A5);
    chk("R5 halt set", 32'(obsHalt), 1);
    chk("R6 no pulse lane0", {29'd0, obsRes, obsExe, obsExc}, 0);
  endtask

  task automatic testResume();
    dmReq(1'b1, 1'b0);
    cpuRd(SREG, rd);
    chk("R2 pending", rd, 32'h00000100);
    repeat (3) @(posedge clk);
    cpuRd(SREG, rd);
    chk("R2 sticky", rd, 32'h00000100);
    cpuWr(SREG, 4'b0010, 32'h0);
    chk("R6 resuming pulse", 32'(obsRes), 1);
    chk("R5 halt cleared", 32'(obsHalt), 0);
    @(posedge clk); #1;
    chk("R6 one cycle", 32'(dmResuming), 0);
    cpuRd(SREG, rd);
    chk("R2 cleared", rd, 0);
  endtask

  task automatic testExec();
    dmReq(1'b0, 1'b1);
    cpuRd(SREG, rd);
    chk("R3 pending", rd, 32'h00010000);
    cpuWr(SREG, 4'b0100, 32'hFFFFFFFF);
    chk("R6 executing pulse", 32'(obsExe), 1);
    cpuRd(SREG, rd);
    chk("R3 cleared", rd, 0);
  endtask

  task automatic testBoth();
    dmReq(1'b1, 1'b1);
    cpuRd(SREG, rd);
    chk("R4 both pending, R7 lanes 0/3 zero", rd, 32'h00010100);
    cpuWr(SREG, 4'b0100, 32'h0);
    cpuRd(SREG, rd);
    chk("R4 exec ack only", rd, 32'h00000100);
    // request and its own acknowledge in one cycle
    @(negedge clk);
    dmResumeReq = 1'b1; cpuAddr = SREG; cpuBe = 4'b0010; cpuWe = 1'b1;
    @(posedge clk); #1;
    dmResumeReq = 1'b0; cpuWe = 1'b0; cpuBe = '0;
    cpuRd(SREG, rd);
    chk("R4 request beats ack", rd, 32'h00000100);
    cpuWr(SREG, 4'b0010, 32'h0);
    cpuRd(SREG, rd);
    chk("R4 final clear", rd, 0);
  endtask

  task automatic testMultiLane();
    cpuWr(SREG, 4'b0001, 32'h0);
    dmReq(1'b1, 1'b1);
    cpuWr(SREG, 4'b1111, 32'h12345678);
    chk("R6 all pulses", {29'd0, obsRes, obsExe, obsExc}, 32'h7);
    chk("R5 clear wins", 32'(obsHalt), 0);
    cpuRd(SREG, rd);
    chk("R7 after multi-lane", rd, 0);
    cpuWr(SREG, 4'b1000, 32'h0);
    chk("R6 exception only", {29'd0, obsRes, obsExe, obsExc}, 32'h1);
  endtask

  task automatic testPbuf();
    @(negedge clk);
    dmPbufWe = 1'b1; dmPbufIdx = 4'd0; dmPbufWdata = 32'hCAFE0001;
    @(negedge clk);
    dmPbufIdx = 4'd15; dmPbufWdata = 32'hCAFE000F;
    @(negedge clk);
    dmPbufWe = 1'b0;
    cpuRd(PBUF, rd);
    chk("R8 word 0", rd, 32'hCAFE0001);
    cpuRd(PBUF + 32'd60, rd);
    chk("R8 word 15", rd, 32'hCAFE000F);
    cpuWr(PBUF, 4'b1111, 32'h0BADBAD0);
    cpuRd(PBUF, rd);
    chk("R8 cpu write ignored", rd, 32'hCAFE0001);
  endtask

  task automatic testDbuf();
    cpuWr(DBUF + 32'd12, 4'b1111, 32'h11223344);
    cpuRd(DBUF + 32'd12, rd);
    chk("R9 cpu word", rd, 32'h11223344);
    cpuWr(DBUF + 32'd12, 4'b0100, 32'h00EE0000);
    @(negedge clk); dmDbufIdx = 4'd3; #1;
    chk("R9 byte merge seen by dm", dmDbufRdata, 32'h11EE3344);
    // conflict on word 5, parallel writes on words 6 and 7
    @(negedge clk);
    cpuAddr = DBUF + 32'd20; cpuBe = 4'b1111; cpuWdata = 32'hC0C0C0C0; cpuWe = 1'b1;
    dmDbufWe = 1'b1; dmDbufIdx = 4'd5; dmDbufWdata = 32'hD0D0D0D0;
    @(negedge clk);
    cpuAddr = DBUF + 32'd24; cpuWdata = 32'h66666666;
    dmDbufIdx = 4'd7; dmDbufWdata = 32'h77777777;
    @(negedge clk);
    cpuWe = 1'b0; cpuBe = '0; dmDbufWe = 1'b0;
    cpuRd(DBUF + 32'd20, rd);
    chk("R9 dm wins conflict", rd, 32'hD0D0D0D0);
    cpuRd(DBUF + 32'd24, rd);
    chk("R9 cpu word 6", rd, 32'h66666666);
    @(negedge clk); dmDbufIdx = 4'd7; #1;
    chk("R9 dm word 7", dmDbufRdata, 32'h77777777);
  endtask

  task automatic testOutside();
    cpuWr(32'h000008C0, 4'b0001, 32'h1);
    chk("R10 no halt from outside", 32'(obsHalt), 0);
    dmReq(1'b1, 1'b0);
    cpuWr(32'h000008C0, 4'b0010, 32'h0);
    chk("R10 no pulse from outside", 32'(obsRes), 0);
    cpuRd(32'h000008C0, rd);
    chk("R10 outside reads zero", rd, 0);
    cpuRd(SREG, rd);
    chk("R10 flag kept", rd, 32'h00000100);
    cpuWr(32'h00000880, 4'b1111, 32'hDEADBEEF);
    cpuRd(DBUF, rd);
    chk("R10 dbuf untouched", rd, 0);
    cpuRd(CODE, rd);
    chk("R10 code area zero", rd, 0);
  endtask

  task automatic testHold();
    cpuRd(SREG, rd);
    chk("R11 loaded", rd, 32'h00000100);
    cpuWr(SREG, 4'b0010, 32'h0);
    repeat (2) @(posedge clk); #1;
    chk("R11 held without read", cpuRdata, 32'h00000100);
    cpuRd(SREG, rd);
    chk("R11 reload", rd, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testHalt();
    testResume();
    testExec();
    testBoth();
    testMultiLane();
    testPbuf();
    testDbuf();
    testOutside();
    testHold();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule